// File: doc/BRIEF.md
# Paged Memory Chip-Select Decoder

This block turns the 16-bit address bus of an 8-bit microcontroller into one-hot select lines for a memory system that is larger than the CPU can address directly. It drives eight 16 KB main flash selects, four 8 KB boot/secondary flash selects, a 2 KB SRAM select, a 256-byte control-register window select and one external peripheral select. The upper half of the address space is common to all pages. The lower half is steered by a page field held in an internal page register.

The page register is written and read by the CPU at offset E0h of the control-register window, which is address 82E0h. Besides the page field it holds two qualifier bits. The swap bit puts main segment 7 at the top of memory in place of the boot segments. The unlock bit then lets the relocated boot segments be reached through page 3. Loader code can therefore hand the reset-vector area over to the main flash without exposing the boot code to stray writes.

Top module: `pgdec_top`

## Requirements
- R1: After a synchronous active-low reset the page register is 00h, and a read of 82E0h returns 00h.
- R2: A write cycle (`rd_nwr`=0) to 82E0h with `e_strobe` high stores `wr_data[4:0]` at the clock edge: page in bits 2..0, swap in bit 3, unlock in bit 4. A read cycle at 82E0h returns the register with bits 7..5 zero. Writes with `e_strobe` low, and writes to any other address, leave the register unchanged. `rd_data` is 00h for any other access.
- R3: `regs_cs` is high for 8200h–82FFh and `sram_cs` is high for A000h–A7FFh, whatever the page, swap and unlock values are.
- R4: `periph_cs` is high only when the address is in 8300h–83FFh and `e_strobe` is high.
- R5: On page n (n = 0..3), `main_cs[2n]` is high for 0000h–3FFFh and `main_cs[2n+1]` is high for 4000h–7FFFh. The exception is listed in R10.
- R6: On page 4, `boot_cs[2]` is high for 0000h–1FFFh and `boot_cs[3]` is high for 2000h–3FFFh. No select is high for 4000h–7FFFh.
- R7: On pages 5, 6 and 7, no select is high anywhere in 0000h–7FFFh.
- R8: With swap = 0, `boot_cs[0]` is high for C000h–DFFFh and `boot_cs[1]` is high for E000h–FFFFh on every page.
- R9: With swap = 1, `main_cs[7]` is high for C000h–FFFFh on every page. Neither `boot_cs[0]` nor `boot_cs[1]` is high in that range.
- R10: With swap = 1 on page 3, 4000h–7FFFh holds `boot_cs[0]` at 4000h–5FFFh and `boot_cs[1]` at 6000h–7FFFh when unlock = 1, and no select when unlock = 0.
- R11: 8000h–81FFh, 8400h–9FFFh and A800h–BFFFh assert no select. At most one select is high for any input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 16 | CPU address |
| wr_data | input | 8 | CPU write data |
| rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| e_strobe | input | 1 | Bus data strobe |
| rd_data | output | 8 | Page register readback, 00h when not addressed |
| main_cs | output | 8 | Main flash segment selects, bit i = segment i |
| boot_cs | output | 4 | Secondary flash segment selects, bit j = segment j |
| sram_cs | output | 1 | SRAM select |
| regs_cs | output | 1 | Control-register window select |
| periph_cs | output | 1 | External peripheral select |

## Verification
The decode is swept over a fixed list of addresses that sit on both edges of every region boundary, including the gaps. Each sweep runs with the strobe low and then high. It is repeated for all eight page values with swap and unlock clear, so that page-to-segment mapping errors and leaks into the empty pages show up. Further sweeps run with swap set, once with unlock clear and once with it set. These separate the top-of-memory replacement from the relocated boot window on page 3. Register writes at the wrong offset, and writes without the strobe, confirm that only a qualified write moves the page state.

// File: rtl/pgdec_pkg.sv
// Shared constants for the paged chip-select decoder.
// Assumes a 16-bit CPU address and an 8-bit data bus.
package pgdec_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int N_MAIN    = 8;
    localparam int N_BOOT    = 4;
    localparam int PAGE_W    = 3;
    localparam int REG_W     = PAGE_W + 2;
    localparam int SWAP_BIT  = PAGE_W;
    localparam int UNLK_BIT  = PAGE_W + 1;
    localparam logic [7:0] PAGE_REG_OFS = 8'hE0;
    // Page on which the relocated boot segments appear when swapped and unlocked
    localparam logic [PAGE_W-1:0] BOOT_RELOC_PAGE = 3'd3;
    // Page that carries the two data segments of the secondary flash
    localparam logic [PAGE_W-1:0] BOOT_DATA_PAGE  = 3'd4;
endpackage

// File: rtl/pgdec_page_reg.sv
// Page register: holds the page field plus the swap and unlock qualifiers.
// Assumes the window hit comes from the common decoder and that the bus
// inputs are stable at the rising clock edge.
module pgdec_page_reg
    import pgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              win_hit,
    input  logic [7:0]        offset,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_nwr,
    input  logic              e_strobe,
    output logic [PAGE_W-1:0] page,
    output logic              swap,
    output logic              unlock,
    output logic [DATA_W-1:0] rd_data
);
    logic [REG_W-1:0] reg_q;
    logic             reg_hit;
    logic             wr_en;

    // Address match on the register offset inside the control window
    always_comb begin
        reg_hit = win_hit && (offset == PAGE_REG_OFS);
        wr_en   = reg_hit && !rd_nwr && e_strobe;
    end

    // Register update on a qualified write cycle
    always_ff @(posedge clk) begin
        if (!rst_n)
            reg_q <= '0;
        else if (wr_en)
            reg_q <= wr_data[REG_W-1:0];
    end

    // Field split and readback path
    always_comb begin
        page    = reg_q[PAGE_W-1:0];
        swap    = reg_q[SWAP_BIT];
        unlock  = reg_q[UNLK_BIT];
        rd_data = '0;
        if (reg_hit && rd_nwr)
            rd_data = {{(DATA_W-REG_W){1'b0}}, reg_q};
    end

    // R1
    reset_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (reg_q == '0));
    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(reg_q));
endmodule

// File: rtl/pgdec_common.sv
// Common-region decoder for 8000h-FFFFh. These selects ignore the page field.
// Only the swap bit matters here: it chooses boot segments or main
// segment 7 at the top of memory.
module pgdec_common
    import pgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              e_strobe,
    input  logic              swap,
    output logic              regs_cs,
    output logic              sram_cs,
    output logic              periph_cs,
    output logic [1:0]        boot_top,
    output logic              main_top
);
    logic hi_half;
    logic in_8xxx;
    logic top_q;

    // Region decode of the upper half of the address space
    always_comb begin
        hi_half   = addr[ADDR_W-1];
        in_8xxx   = (addr[15:8] >= 8'h80) && (addr[15:8] <= 8'h8F);
        regs_cs   = hi_half && in_8xxx && (addr[11:8] == 4'h2);
        periph_cs = hi_half && in_8xxx && (addr[11:8] == 4'h3) && e_strobe;
        sram_cs   = (addr[15:11] == 5'b10100);
        top_q     = (addr[15:14] == 2'b11);
        main_top  = top_q && swap;
        boot_top  = '0;
        if (top_q && !swap)
            boot_top[addr[13]] = 1'b1;
    end

    // R4
    periph_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        periph_cs |-> e_strobe);
    // R9
    swap_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && addr[15:14] == 2'b11) |-> (main_top && boot_top == 2'b00));
endmodule

// File: rtl/pgdec_paged.sv
// Paged-region decoder for 0000h-7FFFh. The page field picks a main flash
// pair or the secondary data segments. Swap removes main segment 7, and
// unlock opens the relocated boot window on page 3.
module pgdec_paged
    import pgdec_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    input  logic              swap,
    input  logic              unlock,
    output logic [N_MAIN-1:0] main_pg,
    output logic [N_BOOT-1:0] boot_pg
);
    logic lo_half;
    assign lo_half = !addr[ADDR_W-1];

    // One decode term per main segment: page = seg/2, half = seg%2
    for (genvar g = 0; g < N_MAIN; g++) begin : g_main
        localparam logic [PAGE_W-1:0] SEG_PAGE = PAGE_W'(g / 2);
        localparam logic              SEG_HALF = 1'(g % 2);
        if (g == N_MAIN - 1) begin : g_swappable
            assign main_pg[g] = lo_half && (page == SEG_PAGE) &&
                                (addr[14] == SEG_HALF) && !swap;
        end else begin : g_fixed
            assign main_pg[g] = lo_half && (page == SEG_PAGE) &&
                                (addr[14] == SEG_HALF);
        end
    end

    // Secondary flash in the paged region: data segments and relocated boot
    always_comb begin
        boot_pg = '0;
        if (lo_half && page == BOOT_DATA_PAGE && !addr[14])
            boot_pg[2 + int'(addr[13])] = 1'b1;
        if (lo_half && page == BOOT_RELOC_PAGE && addr[14] && swap && unlock)
            boot_pg[int'(addr[13])] = 1'b1;
    end
endmodule

// File: rtl/pgdec_top.sv
// Top of the paged chip-select decoder. Combines the common and paged
// decoders with the page register. All selects are combinational in the
// address; only the page register is clocked.
module pgdec_top
    import pgdec_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic [7:0]        wr_data,
    input  logic              rd_nwr,
    input  logic              e_strobe,
    output logic [7:0]        rd_data,
    output logic [7:0]        main_cs,
    output logic [3:0]        boot_cs,
    output logic              sram_cs,
    output logic              regs_cs,
    output logic              periph_cs
);
    logic [PAGE_W-1:0] page;
    logic              swap;
    logic              unlock;
    logic [1:0]        boot_top;
    logic              main_top;
    logic [N_MAIN-1:0] main_pg;
    logic [N_BOOT-1:0] boot_pg;

    pgdec_page_reg u_reg (
        .clk(clk), .rst_n(rst_n), .win_hit(regs_cs), .offset(addr[7:0]),
        .wr_data(wr_data), .rd_nwr(rd_nwr), .e_strobe(e_strobe),
        .page(page), .swap(swap), .unlock(unlock), .rd_data(rd_data)
    );

    pgdec_common u_common (
        .clk(clk), .rst_n(rst_n), .addr(addr), .e_strobe(e_strobe),
        .swap(swap), .regs_cs(regs_cs), .sram_cs(sram_cs),
        .periph_cs(periph_cs), .boot_top(boot_top), .main_top(main_top)
    );

    pgdec_paged u_paged (
        .addr(addr), .page(page), .swap(swap), .unlock(unlock),
        .main_pg(main_pg), .boot_pg(boot_pg)
    );

    // Merge the common and paged select vectors
    always_comb begin
        main_cs = main_pg | {main_top, {(N_MAIN-1){1'b0}}};
        boot_cs = boot_pg | {{(N_BOOT-2){1'b0}}, boot_top};
    end

    // R11
    onehot_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({main_cs, boot_cs, sram_cs, regs_cs, periph_cs}));
    // R10
    boot_unlock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (swap && !addr[15] && (boot_cs[1:0] != 2'b00)) |-> unlock);
endmodule

// File: tb/pgdec_top_bench.sv
// Directed bench for the paged chip-select decoder.
module pgdec_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [15:0] addr = 16'h0000;
    logic [7:0] wr_data = 8'h00;
    logic       rd_nwr = 1'b1;
    logic       e_strobe = 1'b0;
    logic [7:0] rd_data;
    logic [7:0] main_cs;
    logic [3:0] boot_cs;
    logic       sram_cs, regs_cs, periph_cs;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pgdec_top u_pgdec_top (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .rd_nwr(rd_nwr), .e_strobe(e_strobe), .rd_data(rd_data),
        .main_cs(main_cs), .boot_cs(boot_cs), .sram_cs(sram_cs),
        .regs_cs(regs_cs), .periph_cs(periph_cs)
    );

    // Expected {main[7:0], boot[3:0], sram, regs, periph} from the requirements
    function automatic logic [14:0] model(input logic [15:0] a, input logic e,
                                          input logic [2:0] pg, input logic sw,
                                          input logic ul);
        logic [7:0] m; logic [3:0] b; logic s, r, p;
        m = '0; b = '0; s = 0; r = 0; p = 0;
        if (a >= 16'h8200 && a <= 16'h82FF) r = 1;
        if (a >= 16'h8300 && a <= 16'h83FF && e) p = 1;
        if (a >= 16'hA000 && a <= 16'hA7FF) s = 1;
        if (a >= 16'hC000) begin
            if (sw) m[7] = 1;
            else if (a < 16'hE000) b[0] = 1;
            else b[1] = 1;
        end
        if (a < 16'h8000) begin
            if (pg <= 3'd3) begin
                if (a < 16'h4000) m[2*pg] = 1;
                else if (pg == 3'd3 && sw) begin
                    if (ul) begin
                        if (a < 16'h6000) b[0] = 1; else b[1] = 1;
                    end
                end else m[2*pg+1] = 1;
            end else if (pg == 3'd4) begin
                if (a < 16'h2000) b[2] = 1;
                else if (a < 16'h4000) b[3] = 1;
            end
        end
        return {m, b, s, r, p};
    endfunction

    function automatic logic [15:0] probe(input int i);
        case (i)
            0: return 16'h0000;  1: return 16'h1FFF;  2: return 16'h2000;
            3: return 16'h3FFF;  4: return 16'h4000;  5: return 16'h5FFF;
            6: return 16'h6000;  7: return 16'h7FFF;  8: return 16'h8000;
            9: return 16'h81FF; 10: return 16'h8200; 11: return 16'h82FF;
           12: return 16'h8300; 13: return 16'h83FF; 14: return 16'h8400;
           15: return 16'h9FFF; 16: return 16'hA000; 17: return 16'hA7FF;
           18: return 16'hA800; 19: return 16'hBFFF; 20: return 16'hC000;
           21: return 16'hDFFF; 22: return 16'hE000; default: return 16'hFFFE;
        endcase
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s addr=%h actual=%h expected=%h", tag, addr, act, exp);
        end
    endtask

    // Qualified or unqualified register write, driven between edges
    task automatic reg_write(input logic [15:0] a, input logic [7:0] d, input logic e);
        @(negedge clk);
        addr = a; wr_data = d; rd_nwr = 1'b0; e_strobe = e;
        @(negedge clk);
        rd_nwr = 1'b1; e_strobe = 1'b0; wr_data = 8'h00;
    endtask

    task automatic read_reg(input string tag, input logic [7:0] exp);
        @(negedge clk);
        addr = 16'h82E0; rd_nwr = 1'b1; e_strobe = 1'b1;
        #1 check(tag, {8'h00, rd_data}, {8'h00, exp});
        e_strobe = 1'b0;
    endtask

    // Sweep all probe addresses with the strobe low and high
    task automatic sweep(input string tag, input logic [2:0] pg, input logic sw, input logic ul);
        for (int ev = 0; ev < 2; ev++) begin
            for (int i = 0; i < 24; i++) begin
                @(negedge clk);
                addr = probe(i); rd_nwr = 1'b1; e_strobe = ev[0];
                #1 check(tag, {1'b0, main_cs, boot_cs, sram_cs, regs_cs, periph_cs},
                         {1'b0, model(addr, e_strobe, pg, sw, ul)});
            end
        end
        e_strobe = 1'b0;
    endtask

    task automatic t_reset;
        read_reg("R1", 8'h00);
        sweep("R1", 3'd0, 1'b0, 1'b0);
    endtask

    task automatic t_register;
        reg_write(16'h82E0, 8'hF2, 1'b1);
        read_reg("R2", 8'h12);
        reg_write(16'h82E0, 8'h05, 1'b0);   // no strobe: ignored
        read_reg("R2", 8'h12);
        reg_write(16'h82E1, 8'h05, 1'b1);   // wrong offset: ignored
        read_reg("R2", 8'h12);
        @(negedge clk); addr = 16'h82E1; rd_nwr = 1'b1; e_strobe = 1'b1;
        #1 check("R2", {8'h00, rd_data}, 16'h0000);
        reg_write(16'h82E0, 8'h00, 1'b1);
        read_reg("R2", 8'h00);
    endtask

    task automatic t_pages;
        for (int p = 0; p < 8; p++) begin
            reg_write(16'h82E0, 8'(p), 1'b1);
            if (p < 4)       sweep("R5", 3'(p), 1'b0, 1'b0);
            else if (p == 4) sweep("R6", 3'(p), 1'b0, 1'b0);
            else             sweep("R7", 3'(p), 1'b0, 1'b0);
        end
        sweep("R8", 3'd7, 1'b0, 1'b0);
    endtask

    task automatic t_swap;
        for (int p = 0; p < 5; p++) begin
            reg_write(16'h82E0, 8'h08 | 8'(p), 1'b1);
            sweep("R9", 3'(p), 1'b1, 1'b0);
        end
        reg_write(16'h82E0, 8'h0B, 1'b1);
        sweep("R10", 3'd3, 1'b1, 1'b0);
        reg_write(16'h82E0, 8'h1B, 1'b1);
        read_reg("R2", 8'h1B);
        sweep("R10", 3'd3, 1'b1, 1'b1);
        reg_write(16'h82E0, 8'h13, 1'b1);
        sweep("R8", 3'd3, 1'b0, 1'b1);
    endtask

    task automatic t_gaps;
        reg_write(16'h82E0, 8'h02, 1'b1);
        sweep("R3", 3'd2, 1'b0, 1'b0);
        sweep("R4", 3'd2, 1'b0, 1'b0);
        sweep("R11", 3'd2, 1'b0, 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_register();
        t_pages();
        t_swap();
        t_gaps();
        // Reset while the page register is non-zero
        reg_write(16'h82E0, 8'h1C, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        read_reg("R1", 8'h00);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule